// File: doc/BRIEF.md
# Timer Master Trigger Output Selector

This block is the master side of a timer-to-timer link. It contains a small up-counter with a programmable wrap value and two compare channels. From these it produces one registered trigger line for downstream timers. A 3-bit mode field selects what drives that line. The choices are a software-forced update, the counter's enable level, the counter's update event, a pulse on each channel-1 compare match, or the compare level of channel 1 or channel 2.

Software programs four words through a write-only port: a control word, the wrap value, and the two compare values. The counter runs when the run bit is set. It also runs while the gate bit is set and the external trigger input is high. A separate single-cycle input forces an update: it clears the counter and counts as an update event.

Top module: `tmr_trig_master`

## Requirements
- R1: After synchronous reset, every configuration field is zero, the counter is zero and `trgo` is low.
- R2: With mode 000 (control word bits [2:0]), a one-cycle high on `ug` makes `trgo` high for exactly the next cycle.
- R3: With mode 001, `trgo` copies the counter enable one cycle later. The enable is the run bit (control bit 3) ORed with the trigger input while the gate bit (control bit 4) is set.
- R4: In mode 001 with the gate active, a rise of `trig_in` shows on `trgo` two clock edges later when the sync bit (control bit 5) is clear, and one edge later when it is set.
- R5: With mode 010, `trgo` pulses high for one cycle on every update event. An update event is a counter wrap or a `ug` pulse, and `ug` also clears the counter.
- R6: With mode 011, `trgo` pulses high for one cycle on every cycle where the enabled counter equals the channel-1 compare value, including back-to-back matches.
- R7: With mode 100 or 101, `trgo` is high while the counter is below the channel-1 or channel-2 compare value, respectively.
- R8: Modes 110 and 111 hold `trgo` low.
- R9: While enabled, the counter steps by one per cycle. It returns to zero on the cycle after it reaches the wrap value, so the period is wrap value + 1 cycles.
- R10: A write to the control word changes `trgo` starting at the second clock edge after the write; the edge that loads the write still uses the old mode.

Configuration addresses on `cfg_addr`: 0 control, 1 wrap value, 2 channel-1 compare, 3 channel-2 compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 16 | Configuration write data (CNT_W) |
| ug | input | 1 | Software update request, one cycle |
| trig_in | input | 1 | External gating trigger |
| trgo | output | 1 | Registered master trigger output |

## Verification
A vector table runs the counter free with several wrap and compare settings in each mode and counts `trgo` high cycles over whole periods. This separates pulse modes (one per period) from level modes (compare value per period) and from the reserved and never-matching cases (zero). Wrap value zero makes matches and updates occur on every cycle, which shows that repeated matches are not suppressed. Directed tests check the exact edge at which `ug`, a gated trigger rise (with and without sync), and a mode write reach the output. A stopped counter with `ug` shows the counter clear through the channel-2 compare level.

// File: rtl/tmr_trig_pkg.sv
package tmr_trig_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [2:0] {
        TM_SWUPD   = 3'b000,
        TM_ENABLE  = 3'b001,
        TM_UPDATE  = 3'b010,
        TM_CMPPULS = 3'b011,
        TM_REF1    = 3'b100,
        TM_REF2    = 3'b101,
        TM_RSV6    = 3'b110,
        TM_RSV7    = 3'b111
    } trg_mode_e;

    typedef struct packed {
        logic      sync;
        logic      gate;
        logic      run;
        trg_mode_e mode;
    } trg_ctrl_t;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_CMP1   = 2'd2;
    localparam logic [1:0] ADDR_CMP2   = 2'd3;

    function automatic trg_ctrl_t unpack_ctrl(input logic [5:0] bits);
        trg_ctrl_t c;
        c.mode = trg_mode_e'(bits[2:0]);
        c.run  = bits[3];
        c.gate = bits[4];
        c.sync = bits[5];
        return c;
    endfunction

endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
    import tmr_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output trg_ctrl_t        ctrl,
    output logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cmp [NUM_CH]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= unpack_ctrl(6'd0);
            reload <= '0;
            for (int i = 0; i < NUM_CH; i++) cmp[i] <= '0;
        end else if (we) begin
            case (addr)
                ADDR_CTRL:   ctrl   <= unpack_ctrl(wdata[5:0]);
                ADDR_RELOAD: reload <= wdata;
                ADDR_CMP1:   cmp[0] <= wdata;
                ADDR_CMP2:   cmp[1] <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ug,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             upd
);

    logic wrap;

    assign wrap = en && (cnt >= reload);
    assign upd  = wrap || ug;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (ug)   cnt <= '0;
        else if (en)   cnt <= wrap ? '0 : cnt + 1'b1;
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en && cnt >= reload) |=> (cnt == '0)) else $error("wrap"); // R9
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (en && !ug && cnt < reload) |=> (cnt == $past(cnt) + 1'b1)) else $error("step"); // R9

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             ref_lvl
);

    assign ref_lvl = (cnt < cmp);

endmodule

// File: rtl/tmr_trig_mux.sv
module tmr_trig_mux
    import tmr_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trg_ctrl_t  ctrl,
    input  logic       trig_in,
    input  logic       ug,
    input  logic       upd,
    input  logic       match1,
    input  logic [NUM_CH-1:0] ref_lvl,
    output logic       trgo
);

    logic trig_q;
    logic en_copy;
    logic sel;

    assign en_copy = ctrl.run | (ctrl.gate & (ctrl.sync ? trig_in : trig_q));

    always_comb begin
        case (ctrl.mode)
            TM_SWUPD:   sel = ug;
            TM_ENABLE:  sel = en_copy;
            TM_UPDATE:  sel = upd;
            TM_CMPPULS: sel = match1;
            TM_REF1:    sel = ref_lvl[0];
            TM_REF2:    sel = ref_lvl[1];
            default:    sel = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
            trgo   <= 1'b0;
        end else begin
            trig_q <= trig_in;
            trgo   <= sel;
        end
    end

    AST_RSV_LOW: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == TM_RSV6 || ctrl.mode == TM_RSV7) |=> !trgo) else $error("rsv"); // R8
    AST_UG_PULSE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == TM_SWUPD && ug) |=> trgo) else $error("ug"); // R2
    AST_UPD_PULSE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == TM_UPDATE && upd) |=> trgo) else $error("upd"); // R5
    AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == TM_CMPPULS && match1) |=> trgo) else $error("match"); // R6
    AST_RUN_COPY: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == TM_ENABLE && ctrl.run) |=> trgo) else $error("run"); // R3

endmodule

// File: rtl/tmr_trig_master.sv
module tmr_trig_master
    import tmr_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             ug,
    input  logic             trig_in,
    output logic             trgo
);

    trg_ctrl_t        ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cmp [NUM_CH];
    logic [CNT_W-1:0] cnt;
    logic             cnt_en;
    logic             upd;
    logic             match1;
    logic [NUM_CH-1:0] ref_lvl;

    tmr_cfg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ctrl(ctrl), .reload(reload), .cmp(cmp)
    );

    assign cnt_en = ctrl.run | (ctrl.gate & trig_in);

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .en(cnt_en), .ug(ug), .reload(reload),
        .cnt(cnt), .upd(upd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_cmp_chan #(.CNT_W(CNT_W)) u_ch (
            .cnt(cnt), .cmp(cmp[g]), .ref_lvl(ref_lvl[g])
        );
    end

    assign match1 = cnt_en && (cnt == cmp[0]);

    tmr_trig_mux u_mux (
        .clk(clk), .rst(rst), .ctrl(ctrl), .trig_in(trig_in), .ug(ug),
        .upd(upd), .match1(match1), .ref_lvl(ref_lvl), .trgo(trgo)
    );

endmodule

// File: tb/tmr_trig_master_bench.sv
`timescale 1ns/1ps
module tmr_trig_master_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = '0;
    logic        ug = 1'b0;
    logic        trig_in = 1'b0;
    logic        trgo;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tmr_trig_master #(.CNT_W(16)) u_tmr_trig_master (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ug(ug), .trig_in(trig_in), .trgo(trgo)
    );

    // fields: mode, wrap value, cmp1, cmp2, expected high cycles over 4 periods
    localparam int NV = 14;
    localparam logic [39:0] VEC [NV] = '{
        {8'd2, 8'd4, 8'd2, 8'd1, 8'd4},   // R5
        {8'd3, 8'd4, 8'd2, 8'd1, 8'd4},   // R6
        {8'd4, 8'd4, 8'd2, 8'd1, 8'd8},   // R7
        {8'd5, 8'd4, 8'd2, 8'd1, 8'd4},   // R7
        {8'd1, 8'd4, 8'd2, 8'd1, 8'd20},  // R3
        {8'd6, 8'd4, 8'd2, 8'd1, 8'd0},   // R8
        {8'd7, 8'd3, 8'd1, 8'd1, 8'd0},   // R8
        {8'd4, 8'd3, 8'd9, 8'd1, 8'd16},  // R7
        {8'd5, 8'd6, 8'd0, 8'd0, 8'd0},   // R7
        {8'd3, 8'd6, 8'd7, 8'd0, 8'd0},   // R6
        {8'd2, 8'd0, 8'd0, 8'd0, 8'd4},   // R9
        {8'd3, 8'd0, 8'd0, 8'd0, 8'd4},   // R6
        {8'd4, 8'd4, 8'd0, 8'd0, 8'd0},   // R7
        {8'd3, 8'd2, 8'd2, 8'd0, 8'd4}    // R6
    };

    task automatic check(input int got, input int exp, input string req, input string what);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_ug();
        @(negedge clk);
        ug = 1'b1;
        @(negedge clk);
        ug = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(int'(trgo), 0, "R1", "trgo after reset");
        // R1: zero wrap value, counter stopped, mode 0: trgo stays low
        repeat (3) @(negedge clk);
        check(int'(trgo), 0, "R1", "trgo idle with reset config");

        for (int v = 0; v < NV; v++) begin
            int hi;
            int per;
            wr(2'd0, 16'h0000);
            pulse_ug();
            wr(2'd1, {8'd0, VEC[v][31:24]});
            wr(2'd2, {8'd0, VEC[v][23:16]});
            wr(2'd3, {8'd0, VEC[v][15:8]});
            wr(2'd0, {8'd0, 5'b00001, VEC[v][34:32]});
            repeat (4) @(negedge clk);
            hi = 0;
            per = int'(VEC[v][31:24]) + 1;
            for (int c = 0; c < 4 * per; c++) begin
                @(negedge clk);
                if (trgo) hi++;
            end
            check(hi, int'(VEC[v][7:0]), "R5/R6/R7/R8/R9 vector", $sformatf("vector %0d high count", v));
        end

        // R2: software update in mode 000
        wr(2'd0, 16'h0000);
        repeat (2) @(negedge clk);
        pulse_ug();
        check(int'(trgo), 1, "R2", "trgo after ug");
        @(negedge clk);
        check(int'(trgo), 0, "R2", "trgo one cycle later");

        // R5: ug is an update event in mode 010
        wr(2'd0, 16'h0002);
        repeat (2) @(negedge clk);
        pulse_ug();
        check(int'(trgo), 1, "R5", "update pulse from ug");
        @(negedge clk);
        check(int'(trgo), 0, "R5", "update pulse width");

        // R5: ug clears counter, seen via channel-2 level
        wr(2'd1, 16'd9);
        wr(2'd3, 16'd1);
        wr(2'd0, 16'h000D);
        repeat (3) @(negedge clk);
        wr(2'd0, 16'h0005);
        repeat (2) @(negedge clk);
        check(int'(trgo), 0, "R5", "stopped counter above cmp2");
        pulse_ug();
        check(int'(trgo), 0, "R5", "level one edge after ug");
        @(negedge clk);
        check(int'(trgo), 1, "R5", "counter cleared by ug");
        @(negedge clk);
        check(int'(trgo), 1, "R5", "cleared counter holds");

        // R3 and R10: run bit write in mode 001
        wr(2'd0, 16'h0001);
        @(negedge clk);
        check(int'(trgo), 0, "R3", "enable copy with run clear");
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 16'h0009;
        @(negedge clk);
        cfg_we = 1'b0;
        check(int'(trgo), 0, "R10", "old mode at loading edge");
        @(negedge clk);
        check(int'(trgo), 1, "R3", "run visible on trgo");
        // R10: switch to reserved mode
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 16'h000E;
        @(negedge clk);
        cfg_we = 1'b0;
        check(int'(trgo), 1, "R10", "enable still shown at loading edge");
        @(negedge clk);
        check(int'(trgo), 0, "R10", "reserved mode takes over");

        // R4: gated trigger without sync, two edges
        wr(2'd0, 16'h0011);
        repeat (2) @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        check(int'(trgo), 0, "R4", "no sync, one edge after trigger");
        @(negedge clk);
        check(int'(trgo), 1, "R4", "no sync, two edges after trigger");
        trig_in = 1'b0;
        repeat (3) @(negedge clk);
        check(int'(trgo), 0, "R4", "gate closed");

        // R4: gated trigger with sync, one edge
        wr(2'd0, 16'h0031);
        repeat (2) @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        check(int'(trgo), 1, "R4", "sync, one edge after trigger");
        trig_in = 1'b0;
        @(negedge clk);
        check(int'(trgo), 0, "R4", "sync, follows fall");

        finish_run();
    end

endmodule